// File: doc/BRIEF.md
# Directory Coherence Home Controller

This block sits at the home node of a small shared-memory multiprocessor. For every memory block it owns, it tracks a directory state (Uncached, Shared or Exclusive) and a presence vector with one bit per processor. It keeps the backing copy of each block's data word in a small flop array. Caches send it read misses, write misses and write-backs over one request port. It answers over one message port with data replies, invalidates, fetches, fetch-with-invalidates and write-back acknowledgements.

The controller serves one request at a time, in the order the requests arrive. A miss on a block that another cache holds modified is a two-phase transaction. The controller first sends a fetch to the owner. It then waits in a busy state until that owner's write-back for the same block comes in. Only after that does it reply to the requester. Both ports use a valid/ready handshake, and a message is held steady until it is taken.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector and a zero data word, `req_ready_o` is 1 and `rsp_valid_o` is 0.
- R2: A read miss (request type 0) on an Uncached block returns a data reply (message type 0) carrying the stored word to the requester. The block becomes Shared with only the requester present.
- R3: A write miss (request type 1) on an Uncached block returns a data reply with the stored word. The block becomes Exclusive with the requester as the only owner.
- R4: A read miss on a Shared block returns a data reply with the stored word and adds the requester to the presence vector.
- R5: A write miss on a Shared block first sends one invalidate (message type 1) to each present processor other than the requester, in ascending processor id order. It then sends the data reply. The block becomes Exclusive with only the requester present.
- R6: A read miss on an Exclusive block sends a fetch (message type 2) to the owner. When the owner's write-back arrives, that word is stored and returned in the data reply. The block becomes Shared with both the old owner and the requester present.
- R7: A write miss on an Exclusive block sends a fetch-and-invalidate (message type 3) to the owner. The written-back word is stored and returned in the data reply. The block stays Exclusive with only the requester present.
- R8: A write-back (request type 2) from the owner of an Exclusive block stores its word and makes the block Uncached with an empty vector. Any other write-back leaves the block unchanged. Every unsolicited write-back is answered with an acknowledge (message type 4, data 0).
- R9: While waiting for a solicited write-back, `req_ready_o` is 1 only for a write-back from the fetched owner to the block in progress. Every other request is stalled.
- R10: Each request other than a solicited write-back ends with exactly one reply (data or acknowledge) to its requester. A message is held unchanged while `rsp_valid_o` is high and `rsp_ready_i` is low. No request is accepted while a message is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request accepted this cycle when high with valid |
| req_type_i | input | 2 | 0 read miss, 1 write miss, 2 write-back |
| req_pid_i | input | $clog2(N_PROC) | Sending processor id |
| req_addr_i | input | $clog2(N_BLK) | Block address |
| req_data_i | input | DW | Write-back data word |
| rsp_valid_o | output | 1 | Outgoing message valid |
| rsp_ready_i | input | 1 | Outgoing message taken |
| rsp_type_o | output | 3 | 0 data, 1 invalidate, 2 fetch, 3 fetch-and-invalidate, 4 acknowledge |
| rsp_pid_o | output | $clog2(N_PROC) | Destination processor id |
| rsp_addr_o | output | $clog2(N_BLK) | Block address |
| rsp_data_o | output | DW | Data word (0 unless a data reply) |

## Verification
Directed sequences drive each block through every state and request pair. One is a read chain that builds up three sharers before a write miss, which shows whether invalidates are skipped for the requester and sent in id order. Another is an owner chain that separates fetch from fetch-and-invalidate and shows whether the written-back word reaches both memory and the reply. Stray write-backs from non-owners and to Uncached blocks show whether ignored requests leave the state alone. Intruding requests during the fetch wait test the stall. Seeded random traffic over four hot blocks, with a randomly stalling message port, mixes all transitions and checks that held messages stay stable. Every result is checked against a bench-side directory model.

// File: rtl/dir_pkg.sv
package dir_pkg;
  typedef enum logic [1:0] {
    REQ_RD  = 2'd0,
    REQ_WR  = 2'd1,
    REQ_WB  = 2'd2,
    REQ_RSV = 2'd3
  } req_e;

  typedef enum logic [2:0] {
    RSP_DATA      = 3'd0,
    RSP_INV       = 3'd1,
    RSP_FETCH     = 3'd2,
    RSP_FETCH_INV = 3'd3,
    RSP_ACK       = 3'd4
  } rsp_e;

  typedef enum logic [1:0] {
    BLK_UNC = 2'd0,
    BLK_SHR = 2'd1,
    BLK_EXC = 2'd2
  } blk_e;

  typedef enum logic [2:0] {
    FSM_IDLE,
    FSM_INV,
    FSM_FETCH,
    FSM_WAIT,
    FSM_REPLY
  } fsm_e;
endpackage

// File: rtl/dir_lowbit.sv
module dir_lowbit #(
  parameter int W = 4,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  mask_i,
  output logic [IW-1:0] idx_o,
  output logic          any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask_i[i]) begin
        idx_o = IW'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dir_store.sv
module dir_store
  import dir_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int N_BLK  = 16,
  parameter int DW     = 32,
  localparam int AW = $clog2(N_BLK)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [AW-1:0]     addr_i,
  input  logic              st_we_i,
  input  blk_e              st_i,
  input  logic [N_PROC-1:0] sh_i,
  input  logic              mem_we_i,
  input  logic [DW-1:0]     data_i,
  output blk_e              st_o,
  output logic [N_PROC-1:0] sh_o,
  output logic [DW-1:0]     data_o
);
  blk_e              st_all  [N_BLK];
  logic [N_PROC-1:0] sh_all  [N_BLK];
  logic [DW-1:0]     mem_all [N_BLK];

  for (genvar b = 0; b < N_BLK; b++) begin : g_blk
    blk_e              st_r;
    logic [N_PROC-1:0] sh_r;
    logic [DW-1:0]     mem_r;
    logic              hit;

    assign hit = (addr_i == AW'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_r  <= BLK_UNC;
        sh_r  <= '0;
        mem_r <= '0;
      end else begin
        if (st_we_i && hit) begin
          st_r <= st_i;
          sh_r <= sh_i;
        end
        if (mem_we_i && hit) mem_r <= data_i;
      end
    end

    assign st_all[b]  = st_r;
    assign sh_all[b]  = sh_r;
    assign mem_all[b] = mem_r;
  end

  assign st_o   = st_all[addr_i];
  assign sh_o   = sh_all[addr_i];
  assign data_o = mem_all[addr_i];
endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
  import dir_pkg::*;
#(
  parameter int N_PROC = 4,
  parameter int N_BLK  = 16,
  parameter int DW     = 32,
  localparam int PW = $clog2(N_PROC),
  localparam int AW = $clog2(N_BLK)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic [1:0]    req_type_i,
  input  logic [PW-1:0] req_pid_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_data_i,
  output logic          rsp_valid_o,
  input  logic          rsp_ready_i,
  output logic [2:0]    rsp_type_o,
  output logic [PW-1:0] rsp_pid_o,
  output logic [AW-1:0] rsp_addr_o,
  output logic [DW-1:0] rsp_data_o
);
  fsm_e              state_q, state_d;
  req_e              cur_type_q, cur_type_d;
  logic [PW-1:0]     cur_pid_q, cur_pid_d, owner_q, owner_d;
  logic [AW-1:0]     cur_addr_q, cur_addr_d;
  logic [N_PROC-1:0] inv_q, inv_d;
  logic [DW-1:0]     rdata_q, rdata_d;
  rsp_e              rtype_q, rtype_d;

  logic [AW-1:0]     blk_addr;
  blk_e              rd_st, wr_st;
  logic [N_PROC-1:0] rd_sh, wr_sh, req_bit, cur_bit, own_bit;
  logic [DW-1:0]     rd_data, mem_wdata;
  logic              st_we, mem_we, acc, wb_match;
  logic [PW-1:0]     sh_idx, inv_idx;
  logic              sh_any, inv_any;

  assign blk_addr = (state_q == FSM_IDLE) ? req_addr_i : cur_addr_q;
  assign req_bit  = N_PROC'(1) << req_pid_i;
  assign cur_bit  = N_PROC'(1) << cur_pid_q;
  assign own_bit  = N_PROC'(1) << owner_q;

  dir_store #(.N_PROC(N_PROC), .N_BLK(N_BLK), .DW(DW)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (blk_addr),
    .st_we_i (st_we),
    .st_i    (wr_st),
    .sh_i    (wr_sh),
    .mem_we_i(mem_we),
    .data_i  (mem_wdata),
    .st_o    (rd_st),
    .sh_o    (rd_sh),
    .data_o  (rd_data)
  );

  // owner of an Exclusive block, and next sharer to invalidate
  dir_lowbit #(.W(N_PROC)) u_own (.mask_i(rd_sh), .idx_o(sh_idx),  .any_o(sh_any));
  dir_lowbit #(.W(N_PROC)) u_inv (.mask_i(inv_q), .idx_o(inv_idx), .any_o(inv_any));

  assign wb_match = req_valid_i && (req_type_i == REQ_WB) &&
                    (req_pid_i == owner_q) && (req_addr_i == cur_addr_q);
  assign req_ready_o = (state_q == FSM_IDLE) || ((state_q == FSM_WAIT) && wb_match);
  assign acc = req_valid_i && req_ready_o;

  always_comb begin
    state_d    = state_q;
    cur_type_d = cur_type_q;
    cur_pid_d  = cur_pid_q;
    cur_addr_d = cur_addr_q;
    owner_d    = owner_q;
    inv_d      = inv_q;
    rdata_d    = rdata_q;
    rtype_d    = rtype_q;
    st_we      = 1'b0;
    wr_st      = rd_st;
    wr_sh      = rd_sh;
    mem_we     = 1'b0;
    mem_wdata  = req_data_i;
    unique case (state_q)
      FSM_IDLE: if (acc) begin
        cur_type_d = req_e'(req_type_i);
        cur_pid_d  = req_pid_i;
        cur_addr_d = req_addr_i;
        owner_d    = sh_idx;
        rdata_d    = rd_data;
        rtype_d    = RSP_DATA;
        state_d    = FSM_REPLY;
        case (req_type_i)
          REQ_RD: begin
            if (rd_st == BLK_EXC) state_d = FSM_FETCH;
            else begin
              st_we = 1'b1;
              wr_st = BLK_SHR;
              wr_sh = (rd_st == BLK_SHR) ? (rd_sh | req_bit) : req_bit;
            end
          end
          REQ_WR: begin
            if (rd_st == BLK_EXC) state_d = FSM_FETCH;
            else begin
              st_we = 1'b1;
              wr_st = BLK_EXC;
              wr_sh = req_bit;
              if (rd_st == BLK_SHR) begin
                inv_d = rd_sh & ~req_bit;
                if (inv_d != '0) state_d = FSM_INV;
              end
            end
          end
          default: begin
            rtype_d = RSP_ACK;
            rdata_d = '0;
            if (req_type_i == REQ_WB && rd_st == BLK_EXC && rd_sh == req_bit) begin
              st_we  = 1'b1;
              wr_st  = BLK_UNC;
              wr_sh  = '0;
              mem_we = 1'b1;
            end
          end
        endcase
      end
      FSM_INV: if (rsp_ready_i) begin
        inv_d = inv_q & ~(N_PROC'(1) << inv_idx);
        if (inv_d == '0) state_d = FSM_REPLY;
      end
      FSM_FETCH: if (rsp_ready_i) state_d = FSM_WAIT;
      FSM_WAIT: if (acc) begin
        mem_we  = 1'b1;
        rdata_d = req_data_i;
        st_we   = 1'b1;
        if (cur_type_q == REQ_RD) begin
          wr_st = BLK_SHR;
          wr_sh = own_bit | cur_bit;
        end else begin
          wr_st = BLK_EXC;
          wr_sh = cur_bit;
        end
        state_d = FSM_REPLY;
      end
      FSM_REPLY: if (rsp_ready_i) state_d = FSM_IDLE;
      default: state_d = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= FSM_IDLE;
      cur_type_q <= REQ_RD;
      cur_pid_q  <= '0;
      cur_addr_q <= '0;
      owner_q    <= '0;
      inv_q      <= '0;
      rdata_q    <= '0;
      rtype_q    <= RSP_DATA;
    end else begin
      state_q    <= state_d;
      cur_type_q <= cur_type_d;
      cur_pid_q  <= cur_pid_d;
      cur_addr_q <= cur_addr_d;
      owner_q    <= owner_d;
      inv_q      <= inv_d;
      rdata_q    <= rdata_d;
      rtype_q    <= rtype_d;
    end
  end

  assign rsp_valid_o = (state_q == FSM_INV) || (state_q == FSM_FETCH) || (state_q == FSM_REPLY);
  assign rsp_addr_o  = cur_addr_q;
  assign rsp_data_o  = (state_q == FSM_REPLY) ? rdata_q : '0;

  always_comb begin
    rsp_type_o = RSP_DATA;
    rsp_pid_o  = cur_pid_q;
    case (state_q)
      FSM_INV: begin
        rsp_type_o = RSP_INV;
        rsp_pid_o  = inv_idx;
      end
      FSM_FETCH: begin
        rsp_type_o = (cur_type_q == REQ_RD) ? RSP_FETCH : RSP_FETCH_INV;
        rsp_pid_o  = owner_q;
      end
      FSM_REPLY: rsp_type_o = rtype_q;
      default: ;
    endcase
  end
endmodule

// File: rtl/dir_home_ctrl_chk.sv
module dir_home_ctrl_chk #(
  parameter int N_PROC = 4,
  parameter int PW = 2,
  parameter int AW = 4,
  parameter int DW = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [1:0]        req_type_i,
  input logic              rsp_valid_o,
  input logic              rsp_ready_i,
  input logic [2:0]        rsp_type_o,
  input logic [PW-1:0]     rsp_pid_o,
  input logic [AW-1:0]     rsp_addr_o,
  input logic [DW-1:0]     rsp_data_o,
  input logic              st_we,
  input logic [1:0]        st_wstate,
  input logic [N_PROC-1:0] st_wsh,
  input logic              busy,
  input logic [PW-1:0]     cur_pid
);
  AST_RSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && !rsp_ready_i |=> rsp_valid_o && $stable(rsp_type_o) && $stable(rsp_pid_o)
      && $stable(rsp_addr_o) && $stable(rsp_data_o)); // R10
  AST_NO_ACCEPT_WHILE_SENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o); // R10
  AST_EXC_ONE_OWNER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we && st_wstate == 2'd2 |-> $countones(st_wsh) == 1); // R3
  AST_SHR_NONEMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we && st_wstate == 2'd1 |-> st_wsh != '0); // R4
  AST_UNC_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_we && st_wstate == 2'd0 |-> st_wsh == '0); // R8
  AST_INV_SKIP_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o && rsp_type_o == 3'd1 |-> rsp_pid_o != cur_pid); // R5
  AST_BUSY_GATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && req_valid_i && req_type_i != 2'd2 |-> !req_ready_o); // R9
endmodule

bind dir_home_ctrl dir_home_ctrl_chk #(.N_PROC(N_PROC), .PW(PW), .AW(AW), .DW(DW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .req_valid_i(req_valid_i),
  .req_ready_o(req_ready_o),
  .req_type_i (req_type_i),
  .rsp_valid_o(rsp_valid_o),
  .rsp_ready_i(rsp_ready_i),
  .rsp_type_o (rsp_type_o),
  .rsp_pid_o  (rsp_pid_o),
  .rsp_addr_o (rsp_addr_o),
  .rsp_data_o (rsp_data_o),
  .st_we      (st_we),
  .st_wstate  (wr_st),
  .st_wsh     (wr_sh),
  .busy       (state_q != dir_pkg::FSM_IDLE),
  .cur_pid    (cur_pid_q)
);

// File: tb/dir_home_ctrl_tb.sv
`timescale 1ns/1ps
module dir_home_ctrl_tb;
  localparam int NP = 4;
  localparam int NB = 16;
  localparam int DW = 32;
  localparam int PW = $clog2(NP);
  localparam int AW = $clog2(NB);

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n, req_valid, req_ready, rsp_valid, rsp_ready;
  logic [1:0]    req_type;
  logic [PW-1:0] req_pid, rsp_pid;
  logic [AW-1:0] req_addr, rsp_addr;
  logic [DW-1:0] req_data, rsp_data;
  logic [2:0]    rsp_type;

  dir_home_ctrl #(.N_PROC(NP), .N_BLK(NB), .DW(DW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_type_i(req_type),
    .req_pid_i(req_pid), .req_addr_i(req_addr), .req_data_i(req_data),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_type_o(rsp_type),
    .rsp_pid_o(rsp_pid), .rsp_addr_o(rsp_addr), .rsp_data_o(rsp_data)
  );

  int errs = 0, checks = 0;
  int m_st[NB];
  logic [NP-1:0] m_sh[NB];
  logic [DW-1:0] m_mem[NB];
  int e_ty[NP+2], e_pid[NP+2];
  logic [DW-1:0] e_dat[NP+2];
  string e_tag[NP+2];
  int e_n;
  bit hold_p = 0;
  logic [63:0] hold_m = '0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] pk(input int ty, input int pid, input int a, input logic [DW-1:0] d);
    return {8'(ty), 8'(pid), 16'(a), d};
  endfunction

  function automatic logic [63:0] pack_now();
    return pk(int'(rsp_type), int'(rsp_pid), int'(rsp_addr), rsp_data);
  endfunction

  task automatic add(input int ty, input int pid, input logic [DW-1:0] d, input string tag);
    e_ty[e_n] = ty; e_pid[e_n] = pid; e_dat[e_n] = d; e_tag[e_n] = tag; e_n++;
  endtask

  task automatic send(input int ty, input int pid, input int a, input logic [DW-1:0] d);
    int n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_type = 2'(ty); req_pid = PW'(pid); req_addr = AW'(a); req_data = d;
    #1;
    while (!req_ready && n < 300) begin @(negedge clk); #1; n++; end
    if (!req_ready) check(1'b0, "R10", "request never accepted", 64'd0, 64'd1);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic recv(output logic [63:0] m, output bit got);
    got = 0; m = '0;
    for (int n = 0; n < 300 && !got; n++) begin
      @(negedge clk);
      rsp_ready = ($urandom % 10) < 7;
      #1;
      if (hold_p) check(rsp_valid && pack_now() == hold_m, "R10", "stalled message changed", pack_now(), hold_m);
      hold_p = rsp_valid && !rsp_ready;
      hold_m = pack_now();
      if (rsp_valid && rsp_ready) begin m = pack_now(); got = 1; end
    end
  endtask

  task automatic run_req(input int ty, input int pid, input int a, input logic [DW-1:0] d, input bit intr);
    int st = m_st[a];
    logic [NP-1:0] sh = m_sh[a];
    logic [NP-1:0] pb = NP'(1) << pid;
    int own = 0;
    logic [DW-1:0] wbd = $urandom;
    int n_st = st;
    logic [NP-1:0] n_sh = sh;
    logic [DW-1:0] n_mem = m_mem[a];
    logic [63:0] m;
    bit got;
    for (int j = 0; j < NP; j++) if (sh[j]) own = j;
    e_n = 0;
    if (ty == 0 || ty == 1) begin
      if (st == 2) begin
        add(ty == 0 ? 2 : 3, own, '0, ty == 0 ? "R6" : "R7");
        add(0, pid, wbd, ty == 0 ? "R6" : "R7");
        n_mem = wbd;
        if (ty == 0) begin n_st = 1; n_sh = sh | pb; end
        else begin n_st = 2; n_sh = pb; end
      end else if (ty == 0) begin
        add(0, pid, m_mem[a], st == 0 ? "R2" : "R4");
        n_st = 1; n_sh = (st == 0) ? pb : (sh | pb);
      end else begin
        if (st == 1) for (int j = 0; j < NP; j++) if (sh[j] && j != pid) add(1, j, '0, "R5");
        add(0, pid, m_mem[a], st == 0 ? "R3" : "R5");
        n_st = 2; n_sh = pb;
      end
    end else begin
      add(4, pid, '0, "R8");
      if (ty == 2 && st == 2 && own == pid) begin n_st = 0; n_sh = '0; n_mem = d; end
    end
    send(ty, pid, a, d);
    for (int k = 0; k < e_n; k++) begin
      recv(m, got);
      if (!got) begin
        check(1'b0, e_tag[k], "message missing", 64'd0, pk(e_ty[k], e_pid[k], a, e_dat[k]));
        return;
      end
      check(m == pk(e_ty[k], e_pid[k], a, e_dat[k]), e_tag[k], "message", m, pk(e_ty[k], e_pid[k], a, e_dat[k]));
      if (e_ty[k] == 2 || e_ty[k] == 3) begin
        if (intr) begin
          @(negedge clk);
          req_valid = 1'b1; req_type = 2'd0; req_pid = PW'((own + 1) % NP); req_addr = AW'(a); req_data = '0;
          #1 check(!req_ready, "R9", "read accepted while waiting", 64'(req_ready), 64'd0);
          @(negedge clk);
          req_type = 2'd2;
          #1 check(!req_ready, "R9", "non-owner write-back accepted", 64'(req_ready), 64'd0);
          @(negedge clk);
          req_pid = PW'(own); req_addr = AW'((a + 1) % NB);
          #1 check(!req_ready, "R9", "write-back to other block accepted", 64'(req_ready), 64'd0);
          req_valid = 1'b0;
        end
        send(2, own, a, wbd);
      end
    end
    @(negedge clk);
    rsp_ready = 1'b1;
    #1 check(!rsp_valid, "R10", "extra message after reply", 64'(rsp_valid), 64'd0);
    hold_p = 0;
    m_st[a] = n_st; m_sh[a] = n_sh; m_mem[a] = n_mem;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd2024);
    for (int b = 0; b < NB; b++) begin m_st[b] = 0; m_sh[b] = '0; m_mem[b] = '0; end
    rst_n = 1'b0; req_valid = 1'b0; req_type = '0; req_pid = '0; req_addr = '0; req_data = '0;
    rsp_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
    check(rsp_valid == 1'b0, "R1", "no message after reset", 64'(rsp_valid), 64'd0);

    // directed: sharing chain, upgrade, owner chains, stray write-backs
    run_req(0, 0, 3, '0, 0);            // R2, zero word from reset (R1)
    run_req(0, 1, 3, '0, 0);            // R4
    run_req(0, 2, 3, '0, 0);            // R4
    run_req(1, 1, 3, '0, 0);            // R5: inv p0, p2
    run_req(0, 3, 3, '0, 1);            // R6 with R9 intruders
    run_req(1, 0, 3, '0, 0);            // R5: inv p1, p3
    run_req(1, 2, 5, '0, 0);            // R3
    run_req(1, 3, 5, '0, 1);            // R7 with R9 intruders
    run_req(2, 1, 5, 32'hDEAD0001, 0);  // R8 non-owner write-back ignored
    run_req(2, 3, 5, 32'hC0FFEE55, 0);  // R8 owner write-back
    run_req(0, 0, 5, '0, 0);            // R2 sees written-back word
    run_req(2, 2, 7, 32'h12345678, 0);  // R8 write-back to Uncached ignored
    run_req(0, 1, 7, '0, 0);            // R2 memory still zero

    for (int i = 0; i < 400; i++) begin
      int r = $urandom % 100;
      int ty = (r < 45) ? 0 : (r < 80) ? 1 : 2;
      run_req(ty, $urandom % NP, $urandom % 4, $urandom, ($urandom % 4) == 0);
    end

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule